// File: doc/BRIEF.md
# Hardwired Multi-Cycle Control Sequencer

This block is the control unit of a small multi-cycle processor. A step register advances once per clock. Fixed combinational decode logic combines the current step with the opcode in the instruction register. From these two values it produces every control strobe for that clock: bus drive, memory read and write, register write, ALU operation, PC write and instruction load. The block also contains the program counter and the instruction register, because it alone decides when each of them may change.

Every instruction starts with the same three fetch steps. In the first step the PC drives the address bus. In the second step memory is read. In the third step the instruction register captures the data bus and the PC moves forward by one. Most opcodes then finish after one or two execute steps. A multiply opcode is different. It first pulses an initialise strobe. It then holds the sequencer in a shift-and-add loop for a parameterised number of iterations, 32 by default. During the loop the already-incremented PC and the instruction register are frozen, and no new fetch can begin. The datapath, the memory and the multiplier arithmetic are outside the block. It only drives their enables.

Top module: `mc_seq`

## Requirements
- R1: A synchronous active-high reset returns the sequencer to its waiting step and clears the PC and the instruction register to zero. This takes effect whatever step it interrupts, including the middle of a multiply loop.
- R2: In the waiting step, with `go` low, the sequencer stays put. All strobes stay low and the PC and the instruction register keep their values, whatever is on `instr_i`.
- R3: Fetch takes three consecutive clocks once `go` is high in the waiting step. The first clock raises `addr_oe_o`, the second raises `mem_rd_o` with `addr_sel_o` low, and the third raises `ir_ld_o` and `pc_we_o`. After that third clock `ir_o` equals the `instr_i` seen in it and `pc_o` is the old PC plus one, modulo 2^AW.
- R4: `ir_ld_o` is high only in the third fetch step. The instruction register changes at no other time.
- R5: The opcode is `ir_o[15:12]`. Opcodes 1, 2, 3 and 4 (add, subtract, and, or) take one execute step. In that step `reg_we_o` is high and `alu_op_o` is 1, 2, 3 or 4 respectively. `alu_op_o` is 0 (pass) in every step that names no operation.
- R6: Opcode 5 (load) takes two execute steps. The first raises `addr_sel_o` and `mem_rd_o`, the second raises `reg_we_o`. Opcode 6 (store) takes one execute step that raises `addr_sel_o` and `mem_wr_o`.
- R7: Opcode 7 (jump) takes one execute step that raises `pc_we_o`. After that step `pc_o` equals `ir_o[AW-1:0]`.
- R8: Opcode 8 (multiply) takes one execute step that raises `mul_init_o`. It is followed by exactly MUL_ITERS consecutive clocks with `mul_step_o` high and `alu_op_o` = 5 (shift and add), and then the waiting step.
- R9: While `mul_step_o` is high, `pc_we_o` and `ir_ld_o` are low and `pc_o` and `ir_o` do not change.
- R10: Opcodes 0 and 9 to 15 take one execute step with every strobe low.
- R11: `ready_o` is high exactly in the waiting step, and after the last execute step of any instruction the sequencer is back in it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start the next fetch from the waiting step |
| instr_i | input | IW | Instruction word on the memory data bus |
| ready_o | output | 1 | Sequencer is in the waiting step |
| addr_oe_o | output | 1 | Drive the selected address onto the address bus |
| addr_sel_o | output | 1 | Address source: 0 = PC, 1 = instruction operand |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| reg_we_o | output | 1 | Register-file write enable |
| alu_op_o | output | 3 | ALU operation: 0 pass, 1 add, 2 sub, 3 and, 4 or, 5 shift-add |
| mul_init_o | output | 1 | Clear and load the multiplier datapath |
| mul_step_o | output | 1 | One shift and conditional add |
| pc_we_o | output | 1 | PC write enable |
| ir_ld_o | output | 1 | Instruction register load enable |
| pc_o | output | AW | Program counter |
| ir_o | output | IW | Instruction register |

## Verification
The strobes depend combinationally on the registered step and the opcode, so each one is due in the same clock as the step that owns it. `pc_o` and `ir_o` are due one clock after the step that enables them. An instruction therefore lasts 3 fetch clocks plus 1 execute clock for most opcodes, 2 for load, and 1 + MUL_ITERS for multiply. The driver changes inputs one nanosecond after a rising edge and queues one expected vector for that clock. The vector holds all strobes plus the PC and IR the model predicts. The monitor compares it at the following falling edge. Off-fetch clocks carry a different word on `instr_i`, so any stray instruction load shows up in `ir_o`.

// File: rtl/mc_seq_pkg.sv
package mc_seq_pkg;

  localparam int OPW = 4;

  typedef enum logic [2:0] {
    ST_T0   = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_T4   = 3'd4,
    ST_LOOP = 3'd5
  } step_e;

  typedef enum logic [2:0] {
    ALU_PASS  = 3'd0,
    ALU_ADD   = 3'd1,
    ALU_SUB   = 3'd2,
    ALU_AND   = 3'd3,
    ALU_OR    = 3'd4,
    ALU_SHADD = 3'd5
  } alu_e;

  typedef enum logic {
    PC_INC = 1'b0,
    PC_TGT = 1'b1
  } pc_src_e;

  localparam logic [OPW-1:0] OP_NOP = 4'd0;
  localparam logic [OPW-1:0] OP_ADD = 4'd1;
  localparam logic [OPW-1:0] OP_SUB = 4'd2;
  localparam logic [OPW-1:0] OP_AND = 4'd3;
  localparam logic [OPW-1:0] OP_OR  = 4'd4;
  localparam logic [OPW-1:0] OP_LD  = 4'd5;
  localparam logic [OPW-1:0] OP_ST  = 4'd6;
  localparam logic [OPW-1:0] OP_JMP = 4'd7;
  localparam logic [OPW-1:0] OP_MUL = 4'd8;

  typedef struct packed {
    logic    addr_oe;
    logic    addr_sel;
    logic    mem_rd;
    logic    mem_wr;
    logic    reg_we;
    logic    mul_init;
    logic    mul_step;
    logic    pc_we;
    pc_src_e pc_src;
    logic    ir_ld;
    alu_e    alu;
    logic    fin;      // last step of this instruction
    logic    loop_go;  // enter the multiply loop next
  } ctrl_t;

endpackage

// File: rtl/mc_seq_step.sv
module mc_seq_step
  import mc_seq_pkg::*;
#(
  parameter int MUL_ITERS = 32
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  go,
  input  logic  fin,
  input  logic  loop_go,
  output step_e step_o,
  output logic  loop_last_o
);

  localparam int CNT_W = (MUL_ITERS > 1) ? $clog2(MUL_ITERS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MUL_ITERS - 1);

  step_e            step_q;
  logic [CNT_W-1:0] iter_q;

  assign loop_last_o = (iter_q == CNT_LAST);
  assign step_o      = step_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= ST_T0;
      iter_q <= '0;
    end else begin
      unique case (step_q)
        ST_T0: if (go) step_q <= ST_T1;
        ST_T1: step_q <= ST_T2;
        ST_T2: step_q <= ST_T3;
        ST_T3, ST_T4: begin
          if (fin) begin
            step_q <= ST_T0;
          end else if (loop_go) begin
            step_q <= ST_LOOP;
            iter_q <= '0;
          end else begin
            step_q <= step_e'(step_q + 3'd1);
          end
        end
        ST_LOOP: begin
          if (loop_last_o) begin
            step_q <= ST_T0;
            iter_q <= '0;
          end else begin
            iter_q <= iter_q + 1'b1;
          end
        end
        default: step_q <= ST_T0;
      endcase
    end
  end

endmodule

// File: rtl/mc_seq_decode.sv
module mc_seq_decode
  import mc_seq_pkg::*;
(
  input  step_e          step,
  input  logic [OPW-1:0] opcode,
  input  logic           go,
  output ctrl_t          ctrl
);

  always_comb begin
    ctrl        = '0;
    ctrl.alu    = ALU_PASS;
    ctrl.pc_src = PC_INC;
    unique case (step)
      ST_T0: ctrl.addr_oe = go;
      ST_T1: ctrl.mem_rd  = 1'b1;
      ST_T2: begin
        ctrl.ir_ld  = 1'b1;
        ctrl.pc_we  = 1'b1;
        ctrl.pc_src = PC_INC;
      end
      ST_T3: begin
        unique case (opcode)
          OP_ADD: begin ctrl.alu = ALU_ADD; ctrl.reg_we = 1'b1; ctrl.fin = 1'b1; end
          OP_SUB: begin ctrl.alu = ALU_SUB; ctrl.reg_we = 1'b1; ctrl.fin = 1'b1; end
          OP_AND: begin ctrl.alu = ALU_AND; ctrl.reg_we = 1'b1; ctrl.fin = 1'b1; end
          OP_OR:  begin ctrl.alu = ALU_OR;  ctrl.reg_we = 1'b1; ctrl.fin = 1'b1; end
          OP_LD: begin
            ctrl.addr_sel = 1'b1;
            ctrl.mem_rd   = 1'b1;
          end
          OP_ST: begin
            ctrl.addr_sel = 1'b1;
            ctrl.mem_wr   = 1'b1;
            ctrl.fin      = 1'b1;
          end
          OP_JMP: begin
            ctrl.pc_we  = 1'b1;
            ctrl.pc_src = PC_TGT;
            ctrl.fin    = 1'b1;
          end
          OP_MUL: begin
            ctrl.mul_init = 1'b1;
            ctrl.loop_go  = 1'b1;
          end
          default: ctrl.fin = 1'b1;
        endcase
      end
      ST_T4: begin
        ctrl.reg_we = (opcode == OP_LD);
        ctrl.fin    = 1'b1;
      end
      ST_LOOP: begin
        ctrl.mul_step = 1'b1;
        ctrl.alu      = ALU_SHADD;
      end
      default: ctrl.fin = 1'b1;
    endcase
  end

endmodule

// File: rtl/mc_seq_pcir.sv
module mc_seq_pcir
  import mc_seq_pkg::*;
#(
  parameter int IW = 16,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pc_we,
  input  pc_src_e       pc_src,
  input  logic          ir_ld,
  input  logic [IW-1:0] instr_i,
  output logic [AW-1:0] pc_o,
  output logic [IW-1:0] ir_o
);

  logic [AW-1:0] pc_q;
  logic [IW-1:0] ir_q;
  logic [AW-1:0] pc_next;

  assign pc_next = (pc_src == PC_TGT) ? ir_q[AW-1:0] : pc_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
      ir_q <= '0;
    end else begin
      if (pc_we) pc_q <= pc_next;
      if (ir_ld) ir_q <= instr_i;
    end
  end

  assign pc_o = pc_q;
  assign ir_o = ir_q;

endmodule

// File: rtl/mc_seq.sv
module mc_seq
  import mc_seq_pkg::*;
#(
  parameter int IW        = 16,
  parameter int AW        = 12,
  parameter int MUL_ITERS = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [IW-1:0] instr_i,
  output logic          ready_o,
  output logic          addr_oe_o,
  output logic          addr_sel_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic          reg_we_o,
  output logic [2:0]    alu_op_o,
  output logic          mul_init_o,
  output logic          mul_step_o,
  output logic          pc_we_o,
  output logic          ir_ld_o,
  output logic [AW-1:0] pc_o,
  output logic [IW-1:0] ir_o
);

  step_e          step;
  logic           loop_last;
  ctrl_t          ctrl;
  logic [OPW-1:0] opcode;

  assign opcode = ir_o[IW-1 -: OPW];

  mc_seq_step #(.MUL_ITERS(MUL_ITERS)) u_step (
    .clk        (clk),
    .rst        (rst),
    .go         (go),
    .fin        (ctrl.fin),
    .loop_go    (ctrl.loop_go),
    .step_o     (step),
    .loop_last_o(loop_last)
  );

  mc_seq_decode u_dec (
    .step  (step),
    .opcode(opcode),
    .go    (go),
    .ctrl  (ctrl)
  );

  mc_seq_pcir #(.IW(IW), .AW(AW)) u_pcir (
    .clk    (clk),
    .rst    (rst),
    .pc_we  (ctrl.pc_we),
    .pc_src (ctrl.pc_src),
    .ir_ld  (ctrl.ir_ld),
    .instr_i(instr_i),
    .pc_o   (pc_o),
    .ir_o   (ir_o)
  );

  // loop_last is consumed inside the step counter; exposed for the checker
  logic loop_done;
  assign loop_done = loop_last & (step == ST_LOOP);

  assign ready_o    = (step == ST_T0);
  assign addr_oe_o  = ctrl.addr_oe;
  assign addr_sel_o = ctrl.addr_sel;
  assign mem_rd_o   = ctrl.mem_rd;
  assign mem_wr_o   = ctrl.mem_wr;
  assign reg_we_o   = ctrl.reg_we;
  assign alu_op_o   = ctrl.alu;
  assign mul_init_o = ctrl.mul_init;
  assign mul_step_o = ctrl.mul_step;
  assign pc_we_o    = ctrl.pc_we;
  assign ir_ld_o    = ctrl.ir_ld;

endmodule

// File: rtl/mc_seq_chk.sv
module mc_seq_chk #(
  parameter int IW        = 16,
  parameter int AW        = 12,
  parameter int MUL_ITERS = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          go,
  input logic [IW-1:0] instr_i,
  input logic          ready_o,
  input logic          addr_oe_o,
  input logic          addr_sel_o,
  input logic          mem_rd_o,
  input logic          mem_wr_o,
  input logic          reg_we_o,
  input logic [2:0]    alu_op_o,
  input logic          mul_init_o,
  input logic          mul_step_o,
  input logic          pc_we_o,
  input logic          ir_ld_o,
  input logic [AW-1:0] pc_o,
  input logic [IW-1:0] ir_o,
  input logic          loop_done
);

  int run_cnt;
  always_ff @(posedge clk) begin
    if (rst || !mul_step_o) run_cnt <= 0;
    else                    run_cnt <= run_cnt + 1;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> (pc_o == '0 && ir_o == '0 && ready_o));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ready_o && !go) |=> (ready_o && $stable(pc_o) && $stable(ir_o)));

  // R3
  fetch_rd_chk: assert property (@(posedge clk) disable iff (rst)
    addr_oe_o |=> (mem_rd_o && !addr_sel_o));

  // R3
  fetch_ld_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_o && !addr_sel_o) |=> (ir_ld_o && pc_we_o));

  // R4
  ir_capture_chk: assert property (@(posedge clk) disable iff (rst)
    ir_ld_o |=> (ir_o == $past(instr_i) && pc_o == $past(pc_o) + 1'b1));

  // R4
  ir_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ir_ld_o |=> $stable(ir_o));

  // R7
  jump_target_chk: assert property (@(posedge clk) disable iff (rst)
    (pc_we_o && !ir_ld_o) |=> (pc_o == $past(ir_o[AW-1:0])));

  // R8
  mul_enter_chk: assert property (@(posedge clk) disable iff (rst)
    mul_init_o |=> mul_step_o);

  // R8
  mul_continue_chk: assert property (@(posedge clk) disable iff (rst)
    (mul_step_o && run_cnt < MUL_ITERS - 1) |=> mul_step_o);

  // R8
  mul_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (mul_step_o && run_cnt == MUL_ITERS - 1) |-> loop_done);

  // R8
  mul_leave_chk: assert property (@(posedge clk) disable iff (rst)
    loop_done |=> (ready_o && !mul_step_o));

  // R9
  mul_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    mul_step_o |-> (!pc_we_o && !ir_ld_o && alu_op_o == 3'd5));

  // R11
  ready_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> !(mem_rd_o || mem_wr_o || reg_we_o || mul_init_o || mul_step_o || pc_we_o || ir_ld_o || addr_sel_o));

  // R6
  store_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr_o |-> (addr_sel_o && !mem_rd_o));

endmodule

bind mc_seq mc_seq_chk #(.IW(IW), .AW(AW), .MUL_ITERS(MUL_ITERS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .go        (go),
  .instr_i   (instr_i),
  .ready_o   (ready_o),
  .addr_oe_o (addr_oe_o),
  .addr_sel_o(addr_sel_o),
  .mem_rd_o  (mem_rd_o),
  .mem_wr_o  (mem_wr_o),
  .reg_we_o  (reg_we_o),
  .alu_op_o  (alu_op_o),
  .mul_init_o(mul_init_o),
  .mul_step_o(mul_step_o),
  .pc_we_o   (pc_we_o),
  .ir_ld_o   (ir_ld_o),
  .pc_o      (pc_o),
  .ir_o      (ir_o),
  .loop_done (loop_done)
);

// File: tb/mc_seq_tb.sv
module mc_seq_tb;

  localparam int IW = 16;
  localparam int AW = 12;
  localparam int MUL_ITERS = 32;

  // strobe vector: ready, addr_oe, mem_rd, mem_wr, addr_sel, reg_we, mul_init, mul_step, pc_we, ir_ld
  localparam logic [9:0] S_NONE = 10'b0000000000;
  localparam logic [9:0] S_RDY  = 10'b1000000000;
  localparam logic [9:0] S_AOE  = 10'b0100000000;
  localparam logic [9:0] S_RD   = 10'b0010000000;
  localparam logic [9:0] S_WR   = 10'b0001000000;
  localparam logic [9:0] S_ASEL = 10'b0000100000;
  localparam logic [9:0] S_RWE  = 10'b0000010000;
  localparam logic [9:0] S_MINI = 10'b0000001000;
  localparam logic [9:0] S_MSTP = 10'b0000000100;
  localparam logic [9:0] S_PCWE = 10'b0000000010;
  localparam logic [9:0] S_IRLD = 10'b0000000001;

  typedef struct packed {
    logic [9:0]    strb;
    logic [2:0]    alu;
    logic [AW-1:0] pc;
    logic [IW-1:0] ir;
  } obs_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic go = 1'b0;
  logic [IW-1:0] instr_i = '0;
  logic ready_o, addr_oe_o, addr_sel_o, mem_rd_o, mem_wr_o, reg_we_o;
  logic [2:0] alu_op_o;
  logic mul_init_o, mul_step_o, pc_we_o, ir_ld_o;
  logic [AW-1:0] pc_o;
  logic [IW-1:0] ir_o;

  always #5 clk = ~clk;

  mc_seq #(.IW(IW), .AW(AW), .MUL_ITERS(MUL_ITERS)) u_dut (
    .clk(clk), .rst(rst), .go(go), .instr_i(instr_i),
    .ready_o(ready_o), .addr_oe_o(addr_oe_o), .addr_sel_o(addr_sel_o),
    .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .reg_we_o(reg_we_o),
    .alu_op_o(alu_op_o), .mul_init_o(mul_init_o), .mul_step_o(mul_step_o),
    .pc_we_o(pc_we_o), .ir_ld_o(ir_ld_o), .pc_o(pc_o), .ir_o(ir_o)
  );

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;
  obs_t  exp_q[$];
  string tag_q[$];
  logic [AW-1:0] mdl_pc = '0;
  logic [IW-1:0] mdl_ir = '0;

  // monitor: compares one queued expectation per cycle at the falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      obs_t  e;
      obs_t  a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a.strb = {ready_o, addr_oe_o, mem_rd_o, mem_wr_o, addr_sel_o, reg_we_o,
                mul_init_o, mul_step_o, pc_we_o, ir_ld_o};
      a.alu = alu_op_o;
      a.pc  = pc_o;
      a.ir  = ir_o;
      n_tests++;
      if (a !== e) begin
        n_fail++;
        $display("FAIL %s: actual strb=%b alu=%0d pc=%h ir=%h expected strb=%b alu=%0d pc=%h ir=%h",
                 t, a.strb, a.alu, a.pc, a.ir, e.strb, e.alu, e.pc, e.ir);
      end
    end
  end

  task automatic cyc(input logic g, input logic [IW-1:0] w, input logic [9:0] s,
                     input logic [2:0] alu, input string tag);
    obs_t e;
    @(posedge clk);
    #1;
    go = g;
    instr_i = w;
    e.strb = s; e.alu = alu; e.pc = mdl_pc; e.ir = mdl_ir;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 16'h7A5C ^ IW'(i), S_RDY, 3'd0, tag);
  endtask

  task automatic fetch(input logic [IW-1:0] w);
    cyc(1'b1, ~w, S_RDY | S_AOE, 3'd0, "R3 R11");
    cyc(1'b0, ~w, S_RD, 3'd0, "R3");
    cyc(1'b0, w, S_PCWE | S_IRLD, 3'd0, "R3 R4");
    mdl_pc = mdl_pc + 1'b1;
    mdl_ir = w;
  endtask

  task automatic run_instr(input logic [IW-1:0] w);
    logic [3:0] op;
    op = w[15:12];
    fetch(w);
    case (op)
      4'd1, 4'd2, 4'd3, 4'd4: cyc(1'b0, ~w, S_RWE, op[2:0], "R5");
      4'd5: begin
        cyc(1'b0, ~w, S_ASEL | S_RD, 3'd0, "R6");
        cyc(1'b0, ~w, S_RWE, 3'd0, "R6");
      end
      4'd6: cyc(1'b0, ~w, S_ASEL | S_WR, 3'd0, "R6");
      4'd7: begin
        cyc(1'b0, ~w, S_PCWE, 3'd0, "R7");
        mdl_pc = w[AW-1:0];
      end
      4'd8: begin
        cyc(1'b0, ~w, S_MINI, 3'd0, "R8");
        for (int i = 0; i < MUL_ITERS; i++) cyc(1'b0, ~w, S_MSTP, 3'd5, "R8 R9");
      end
      default: cyc(1'b0, ~w, S_NONE, 3'd0, "R10");
    endcase
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    idle(1, "R1");
    idle(3, "R2 R11");
    run_instr(16'h1123);   // add
    run_instr(16'h2456);   // sub
    idle(2, "R2");
    run_instr(16'h3789);   // and
    run_instr(16'h4ABC);   // or
    run_instr(16'h5010);   // load
    run_instr(16'h6020);   // store
    run_instr(16'h0000);   // empty
    run_instr(16'hB3F1);   // undefined
    run_instr(16'hF0F0);   // undefined
    run_instr(16'h7ABC);   // jump
    run_instr(16'h8001);   // multiply
    idle(2, "R2 R11");
    run_instr(16'h8FFF);   // multiply back to back with next
    run_instr(16'h7FFF);   // jump to top of address space
    run_instr(16'h1000);   // fetch wraps PC to zero
    run_instr(16'h5FFF);   // load
    // reset in the middle of a multiply loop
    fetch(16'h8123);
    cyc(1'b0, 16'h7EDC, S_MINI, 3'd0, "R8");
    for (int i = 0; i < 6; i++) cyc(1'b0, 16'h7EDC, S_MSTP, 3'd5, "R9");
    rst = 1'b1;
    mdl_pc = '0;
    mdl_ir = '0;
    cyc(1'b0, 16'h7EDC, S_RDY, 3'd0, "R1");
    rst = 1'b0;
    idle(2, "R1 R2");
    run_instr(16'h2222);
    @(posedge clk);
    @(negedge clk);
    #1;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule